// File: doc/BRIEF.md
# Extended Multiply/Divide Unit

A multi-cycle arithmetic unit for a 16-bit processor core. It takes the current values of the accumulator pair D and the index registers X and Y, together with a two-bit operation code. It returns updated D, X and Y values and the N, Z, V and C condition flags. Four operations are supported: signed 16/16 divide, unsigned 32/16 divide, signed 32/16 divide and signed 16x16 multiply.

Each operation begins when `start` is sampled high while the unit is idle. The unit works on magnitudes with a restoring shift-subtract loop (divides) or a shift-add loop (multiply), then corrects the signs in a final cycle. It then pulses `done` for one cycle. The results stay on the outputs until the next operation completes. A `start` that arrives while the unit is busy is dropped.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, `dOut`, `xOut`, `yOut`, all four flags, `done` and `busy` are 0.
- R2: Op code 2'b00 divides D by X as signed 16-bit values. X receives the quotient, truncated toward zero. D receives the remainder, which has the sign of the dividend. Y is returned unchanged.
- R3: Op code 2'b01 divides the unsigned 32-bit value {Y,D} (Y is the upper half) by the unsigned X. Y receives the low 16 bits of the quotient, D receives the remainder, and X is returned unchanged.
- R4: Op code 2'b10 divides the signed 32-bit value {Y,D} by the signed X, truncating toward zero. Y receives the low 16 bits of the quotient, D receives a remainder with the dividend's sign, and X is returned unchanged.
- R5: After a divide with a nonzero divisor, C is 0. Z is 1 exactly when the quotient is zero, and N equals bit 15 of the quotient.
- R6: V is set after an unsigned divide whose quotient exceeds 65535. V is set after a signed divide whose quotient exceeds 32767 or falls below -32768. Otherwise V is cleared after a divide.
- R7: A divide by a zero X sets C and clears N, Z and V. It returns D, X and Y unchanged.
- R8: Op code 2'b11 multiplies D by Y as signed 16-bit values. D receives product bits 15:0, Y receives bits 31:16, and X is unchanged. Z is set when the 32-bit product is zero, N equals product bit 31, C equals product bit 15, and V is 0.
- R9: `done` is high for exactly one cycle. For a divide it is high in the cycle after the 33rd rising edge following the edge that samples `start`; for the multiply, after the 17th. Results hold until the next `done`.
- R10: While `busy` is high, `start` has no effect: the running operation's results are not altered, and no additional `done` is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| op | input | 2 | Operation code (see R2, R3, R4, R8) |
| dIn | input | 16 | D register value |
| xIn | input | 16 | X register value |
| yIn | input | 16 | Y register value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| dOut | output | 16 | Updated D |
| xOut | output | 16 | Updated X |
| yOut | output | 16 | Updated Y |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| flagV | output | 1 | Overflow flag |
| flagC | output | 1 | Carry / divide-by-zero flag |

## Verification
A divide result is due on the 33rd rising edge after the edge that accepts `start`, and a multiply result on the 17th. The driver records the index of the accepting edge with each expected item. The monitor samples on falling edges, and when it sees `done` it checks that the elapsed edge count equals the latency for that operation. A `done` with no expected item queued counts as a failure. After the busy-window test, the outputs are read again 40 cycles later to confirm they held.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    OP_DIVS16 = 2'b00,
    OP_DIVU32 = 2'b01,
    OP_DIVS32 = 2'b10,
    OP_MULS16 = 2'b11
  } mdOp_e;

  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } mdStrobe_t;
endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      isMulIn,
  output mdStrobe_t strobe,
  output logic      busy,
  output logic      done
);
  localparam int DIV_STEPS = 2 * W;
  localparam int MUL_STEPS = W;
  localparam int CW = $clog2(DIV_STEPS + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} ctrlState_e;

  ctrlState_e      state;
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   lastStep;

  always_comb begin
    strobe.load   = (state == ST_IDLE) && start;
    strobe.step   = (state == ST_RUN);
    strobe.finish = (state == ST_FIN);
    busy          = (state != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      lastStep <= '0;
      done     <= 1'b0;
    end else begin
      done <= strobe.finish;
      case (state)
        ST_IDLE: if (start) begin
          state    <= ST_RUN;
          cnt      <= '0;
          lastStep <= isMulIn ? CW'(MUL_STEPS - 1) : CW'(DIV_STEPS - 1);
        end
        ST_RUN: begin
          cnt <= cnt + 1'b1;
          if (cnt == lastStep) state <= ST_FIN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  done_after_fin_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(state == ST_FIN));

  // R9
  step_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> (cnt <= lastStep));

  // R10
  busy_no_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && start && cnt != lastStep) |=> (state == ST_RUN && cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/muldiv_datapath.sv
module muldiv_datapath
  import muldiv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  mdStrobe_t    strobe,
  input  logic [1:0]   op,
  input  logic [W-1:0] dIn,
  input  logic [W-1:0] xIn,
  input  logic [W-1:0] yIn,
  output logic [W-1:0] dOut,
  output logic [W-1:0] xOut,
  output logic [W-1:0] yOut,
  output logic         flagN,
  output logic         flagZ,
  output logic         flagV,
  output logic         flagC
);
  localparam int W2 = 2 * W;
  localparam logic [W2-1:0] POS_LIMIT = (W2'(1) << (W - 1)) - W2'(1);
  localparam logic [W2-1:0] NEG_LIMIT = W2'(1) << (W - 1);

  mdOp_e        opQ;
  logic [W-1:0] dSave, xSave, ySave;
  logic [W:0]   rem;
  logic [W2-1:0] quo;
  logic [W-1:0] dvs;
  logic         negQ, negR;
  logic [W2-1:0] acc, mcand;
  logic [W-1:0] mplier;

  // load-side operand conditioning
  mdOp_e         opNew;
  logic [W2-1:0] dividendRaw, dividendMag;
  logic          divSigned, dividendNeg, dvsNeg;
  logic [W-1:0]  dvsMag, dMag, yMag;

  always_comb begin
    opNew       = mdOp_e'(op);
    dividendRaw = (opNew == OP_DIVS16) ? {{W{dIn[W-1]}}, dIn} : {yIn, dIn};
    divSigned   = (opNew != OP_DIVU32);
    dividendNeg = divSigned && dividendRaw[W2-1];
    dvsNeg      = divSigned && xIn[W-1];
    dividendMag = dividendNeg ? (~dividendRaw + W2'(1)) : dividendRaw;
    dvsMag      = dvsNeg ? (~xIn + W'(1)) : xIn;
    dMag        = dIn[W-1] ? (~dIn + W'(1)) : dIn;
    yMag        = yIn[W-1] ? (~yIn + W'(1)) : yIn;
  end

  // one restoring division step
  logic [W:0] shifted, trial;
  logic       fits;

  always_comb begin
    shifted = {rem[W-1:0], quo[W2-1]};
    trial   = shifted - {1'b0, dvs};
    fits    = (shifted >= {1'b0, dvs});
  end

  // finishing: sign correction and flags
  logic          isMul, divZero, ovf;
  logic [W2:0]   quoSigned;
  logic [W-1:0]  remSigned;
  logic [W2-1:0] product;

  always_comb begin
    isMul     = (opQ == OP_MULS16);
    divZero   = !isMul && (dvs == '0);
    quoSigned = negQ ? (~{1'b0, quo} + (W2+1)'(1)) : {1'b0, quo};
    remSigned = negR ? (~rem[W-1:0] + W'(1)) : rem[W-1:0];
    if (opQ == OP_DIVU32) ovf = |quo[W2-1:W];
    else if (negQ)        ovf = (quo > NEG_LIMIT);
    else                  ovf = (quo > POS_LIMIT);
    product   = negQ ? (~acc + W2'(1)) : acc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ <= OP_DIVS16;
      {dSave, xSave, ySave} <= '0;
      rem <= '0; quo <= '0; dvs <= '0;
      negQ <= 1'b0; negR <= 1'b0;
      acc <= '0; mcand <= '0; mplier <= '0;
      dOut <= '0; xOut <= '0; yOut <= '0;
      {flagN, flagZ, flagV, flagC} <= '0;
    end else begin
      if (strobe.load) begin
        opQ   <= opNew;
        dSave <= dIn;
        xSave <= xIn;
        ySave <= yIn;
        rem   <= '0;
        quo   <= dividendMag;
        dvs   <= dvsMag;
        acc   <= '0;
        mcand <= {{W{1'b0}}, dMag};
        mplier <= yMag;
        if (opNew == OP_MULS16) begin
          negQ <= dIn[W-1] ^ yIn[W-1];
          negR <= 1'b0;
        end else begin
          negQ <= dividendNeg ^ dvsNeg;
          negR <= dividendNeg;
        end
      end

      if (strobe.step) begin
        if (isMul) begin
          if (mplier[0]) acc <= acc + mcand;
          mcand  <= mcand << 1;
          mplier <= mplier >> 1;
        end else begin
          rem <= fits ? trial : shifted;
          quo <= {quo[W2-2:0], fits};
        end
      end

      if (strobe.finish) begin
        if (isMul) begin
          dOut  <= product[W-1:0];
          xOut  <= xSave;
          yOut  <= product[W2-1:W];
          flagN <= product[W2-1];
          flagZ <= (product == '0);
          flagV <= 1'b0;
          flagC <= product[W-1];
        end else if (divZero) begin
          dOut  <= dSave;
          xOut  <= xSave;
          yOut  <= ySave;
          {flagN, flagZ, flagV} <= '0;
          flagC <= 1'b1;
        end else begin
          dOut  <= remSigned;
          if (opQ == OP_DIVS16) begin
            xOut <= quoSigned[W-1:0];
            yOut <= ySave;
          end else begin
            xOut <= xSave;
            yOut <= quoSigned[W-1:0];
          end
          flagN <= quoSigned[W-1];
          flagZ <= (quo == '0);
          flagV <= ovf;
          flagC <= 1'b0;
        end
      end
    end
  end

  // R7
  zero_div_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finish && divZero) |=> (flagC && !flagN && !flagZ && !flagV));

  // R7
  zero_div_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finish && divZero) |=> (dOut == $past(dSave) && xOut == $past(xSave) && yOut == $past(ySave)));

  // R8
  mul_no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finish && isMul) |=> !flagV);

  // R2
  rem_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finish && !isMul && !divZero) |-> (rem < {1'b0, dvs}));

  // R5
  div_carry_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finish && !isMul && !divZero) |=> !flagC);
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] dIn,
  input  logic [W-1:0] xIn,
  input  logic [W-1:0] yIn,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] dOut,
  output logic [W-1:0] xOut,
  output logic [W-1:0] yOut,
  output logic         flagN,
  output logic         flagZ,
  output logic         flagV,
  output logic         flagC
);
  mdStrobe_t strobe;
  logic      isMulIn;

  assign isMulIn = (op == OP_MULS16);

  muldiv_ctrl #(.W(W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .isMulIn(isMulIn),
    .strobe(strobe), .busy(busy), .done(done)
  );

  muldiv_datapath #(.W(W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .op(op),
    .dIn(dIn), .xIn(xIn), .yIn(yIn),
    .dOut(dOut), .xOut(xOut), .yOut(yOut),
    .flagN(flagN), .flagZ(flagZ), .flagV(flagV), .flagC(flagC)
  );
endmodule

// File: tb/muldiv_unit_test.sv
module muldiv_unit_test;
  localparam int PERIOD = 10;
  localparam int DIV_LAT = 33;
  localparam int MUL_LAT = 17;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [15:0] dIn = '0, xIn = '0, yIn = '0;
  logic        busy, done, flagN, flagZ, flagV, flagC;
  logic [15:0] dOut, xOut, yOut;

  muldiv_unit uut (
    .clk(clk), .rstN(rstN), .start(start), .op(op),
    .dIn(dIn), .xIn(xIn), .yIn(yIn),
    .busy(busy), .done(done), .dOut(dOut), .xOut(xOut), .yOut(yOut),
    .flagN(flagN), .flagZ(flagZ), .flagV(flagV), .flagC(flagC)
  );

  always #(PERIOD / 2) clk = ~clk;

  typedef struct packed {
    logic [15:0] d, x, y;
    logic n, z, v, c;
  } res_t;

  typedef struct {
    res_t  res;
    int    lat;
    int    startEdge;
    string req;
  } item_t;

  item_t q[$];
  res_t  lastRes;
  int    cyc = 0;
  int    nChecks = 0;
  int    nFails = 0;
  bit    finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic res_t model(input logic [1:0] o, input logic [15:0] d, x, y);
    res_t e;
    longint a, b, qv, rv, p;
    e = '{d: d, x: x, y: y, n: 1'b0, z: 1'b0, v: 1'b0, c: 1'b0};
    if (o == 2'b11) begin
      p = longint'($signed(d)) * longint'($signed(y));
      e.d = p[15:0];
      e.y = p[31:16];
      e.z = (p[31:0] == 32'd0);
      e.n = p[31];
      e.c = p[15];
      return e;
    end
    if (x == 16'd0) begin
      e.c = 1'b1;
      return e;
    end
    case (o)
      2'b00: begin a = longint'($signed(d)); b = longint'($signed(x)); end
      2'b01: begin a = longint'({32'd0, y, d}); b = longint'({48'd0, x}); end
      default: begin a = longint'($signed({y, d})); b = longint'($signed(x)); end
    endcase
    qv = a / b;
    rv = a % b;
    e.v = (o == 2'b01) ? (qv > 65535) : (qv > 32767 || qv < -32768);
    e.z = (qv == 0);
    e.n = qv[15];
    e.d = rv[15:0];
    if (o == 2'b00) e.x = qv[15:0];
    else            e.y = qv[15:0];
    return e;
  endfunction

  // monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (rstN && done) begin
      if (q.size() == 0) begin
        check(1'b0, "R10 unexpected done", 64'(cyc), 64'd0);
      end else begin
        item_t it;
        res_t  act;
        it  = q.pop_front();
        act = '{d: dOut, x: xOut, y: yOut, n: flagN, z: flagZ, v: flagV, c: flagC};
        check(act == it.res, it.req, 64'(act), 64'(it.res));
        check(cyc - it.startEdge == it.lat, "R9 latency", 64'(cyc - it.startEdge), 64'(it.lat));
        lastRes = act;
      end
    end
  end

  task automatic issue(input logic [1:0] o, input logic [15:0] d, x, y, input string req);
    item_t it;
    @(negedge clk);
    op = o; dIn = d; xIn = x; yIn = y; start = 1'b1;
    it.res = model(o, d, x, y);
    it.lat = (o == 2'b11) ? MUL_LAT : DIV_LAT;
    it.startEdge = cyc + 1;
    it.req = req;
    q.push_back(it);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitIdle();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic runOp(input logic [1:0] o, input logic [15:0] d, x, y, input string req);
    issue(o, d, x, y, req);
    waitIdle();
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      check(1'b0, "watchdog", 64'(cyc), 64'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check({dOut, xOut, yOut, flagN, flagZ, flagV, flagC, done, busy} == '0, "R1 reset",
          64'({dOut, xOut, yOut, flagN, flagZ, flagV, flagC, done, busy}), 64'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2 signed 16/16
    runOp(2'b00, 16'd100, 16'd7, 16'hABCD, "R2 100/7");
    runOp(2'b00, -16'sd100, 16'd7, 16'h1234, "R2 -100/7");
    runOp(2'b00, 16'd100, -16'sd7, 16'h0000, "R2 100/-7");
    runOp(2'b00, 16'h8000, 16'hFFFF, 16'h5555, "R6 -32768/-1");
    // R3 unsigned 32/16
    runOp(2'b01, 16'h0000, 16'd3, 16'h0001, "R3 65536/3");
    runOp(2'b01, 16'h5678, 16'h1234, 16'h1234, "R3 mixed");
    runOp(2'b01, 16'h0000, 16'd2, 16'h0005, "R6 unsigned overflow");
    runOp(2'b01, 16'hFFFF, 16'hFFFF, 16'hFFFF, "R6 max dividend");
    // R4 signed 32/16
    runOp(2'b10, 16'hBDC0, 16'd7, 16'hFFF0, "R4 negative dividend");
    runOp(2'b10, 16'h4240, -16'sd300, 16'h000F, "R4 negative divisor");
    runOp(2'b10, 16'h0000, 16'hFFFF, 16'h8000, "R6 min/-1");
    runOp(2'b10, 16'd5, 16'd9, 16'h0000, "R5 zero quotient");
    // R7 divide by zero
    runOp(2'b00, 16'h1111, 16'h0000, 16'h2222, "R7 16/16 zero");
    runOp(2'b01, 16'h3333, 16'h0000, 16'h4444, "R7 unsigned zero");
    runOp(2'b10, 16'h5555, 16'h0000, 16'h6666, "R7 signed zero");
    // R8 multiply
    runOp(2'b11, 16'd300, 16'h9999, -16'sd7, "R8 300*-7");
    runOp(2'b11, 16'h8000, 16'h0001, 16'h8000, "R8 min*min");
    runOp(2'b11, 16'h0000, 16'h0002, 16'd5, "R8 zero product");
    runOp(2'b11, 16'h00FF, 16'h0003, 16'h0081, "R8 carry bit15");

    // R10 start ignored while busy
    issue(2'b01, 16'h5678, 16'h0077, 16'h0012, "R10 busy run");
    repeat (5) @(negedge clk);
    op = 2'b11; dIn = 16'h0F0F; xIn = 16'h0; yIn = 16'h7070; start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    waitIdle();
    repeat (40) @(negedge clk);
    // R9 results hold / R10 no extra done
    check({dOut, xOut, yOut, flagN, flagZ, flagV, flagC} == lastRes, "R9 hold after busy start",
          64'({dOut, xOut, yOut, flagN, flagZ, flagV, flagC}), 64'(lastRes));
    check(!busy && !done, "R10 idle after ignored start", 64'({busy, done}), 64'd0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule